// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns characters written by a host into asynchronous serial frames. A character first lands in a one-entry holding buffer. From there it is handed to a transmit shift register as soon as the shifter has nothing to send. The shifter puts a low start bit, the data bits least significant first and a high stop bit onto the serial line. Each bit changes on a baud tick that a divisor outside the block supplies.

Because the holding stage is separate from the shifter, the host can queue the next character while the current one is still going out. The queued character then follows the previous stop bit with no idle time. Two flags report the two stages: a buffer-empty flag, which can be gated into an interrupt request, and a shifter-empty flag, which the host polls. An optional ninth data bit is latched by its own write strobe ahead of the data byte, for example to mark a frame as an address.

Top module: `dbuf_serial_tx`

## Requirements
- R1: While reset is asserted and afterwards until enabled, the line `ser_out` is 1, `shift_empty` is 1, `buf_empty` is 0, `overflow` is 0 and `irq` is 0.
- R2: With `tx_en` at 1, `buf_empty` reads 1 whenever the holding buffer holds no character, and `irq` equals `buf_empty` AND `irq_en`.
- R3: A data write to an empty buffer while the shifter is idle makes `buf_empty` read 0 for exactly one cycle after the write edge, with `shift_empty` still 1. In the following cycle `buf_empty` reads 1 again and `shift_empty` reads 0.
- R4: A frame is a 0 start bit, then the data bits least significant first, then a 1 stop bit. Each bit is held from one baud tick to the next, and the line is 1 whenever nothing is being sent. The first bit appears on the first baud tick after the character enters the shifter.
- R5: With `nine_mode` at 1 when a character enters the shifter, the frame carries nine data bits. The ninth (most significant) bit is the value last latched by `ninth_wr` before the data write. Changing the latched ninth bit after the data write does not alter that character.
- R6: `shift_empty` stays 0 until the baud tick that ends the stop bit. It rises (frame bits × tick period) system cycles after the start bit appears: 10 bits in 8-bit mode, 11 bits in 9-bit mode.
- R7: A character waiting in the holding buffer starts its start bit on the same tick that ends the previous stop bit. Consecutive start bits are exactly one frame length apart.
- R8: A data write while the buffer is full, and the buffer is not handing its character to the shifter in that cycle, is ignored. The write sets `overflow`, which stays 1 until the transmitter is disabled.
- R9: A data write in the same cycle as the buffer hands its character to the shifter is accepted and does not set `overflow`.
- R10: Driving `tx_en` to 0 aborts any frame. One cycle later the line is 1, `shift_empty` is 1, `buf_empty` is 0 and `overflow` is 0. Data writes made while disabled are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable; 0 aborts and empties both stages |
| irq_en | input | 1 | Gates the buffer-empty flag onto `irq` |
| nine_mode | input | 1 | 1 selects nine data bits per frame |
| ninth_wr | input | 1 | Strobe latching `ninth_val` as the next ninth bit |
| ninth_val | input | 1 | Ninth data bit value |
| data_wr | input | 1 | Strobe writing `data_byte` into the holding buffer |
| data_byte | input | 8 | Low eight data bits of the character |
| baud_tick | input | 1 | One-cycle bit-rate pulse |
| ser_out | output | 1 | Serial line, idle high |
| buf_empty | output | 1 | Holding buffer can accept a character |
| shift_empty | output | 1 | Shift register holds nothing (polled) |
| overflow | output | 1 | Sticky: a write was dropped because the buffer was full |
| irq | output | 1 | Buffer-empty interrupt request |

## Verification
Two functions can fall in one cycle: a host write to the holding buffer, and the hand-over of the buffered character to the shifter on the tick that ends a stop bit. The bench counts the baud ticks issued since a known character entered the shifter. It can then place a third write exactly on the hand-over tick, where the write must be accepted with no overflow, or one tick earlier, where it must be dropped and flagged. The decoded line stream then shows three characters or two.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = BYTE_W + 1;
    localparam int FRAME_MAX = WORD_W + 2;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);

    typedef struct packed {
        logic              full;
        logic [WORD_W-1:0] word;
        logic              ninth;
        logic              ovf;
    } hold_state_t;

    typedef struct packed {
        logic                 busy;
        logic [FRAME_MAX-1:0] sreg;
        logic [CNT_W-1:0]     left;
        logic                 line;
    } shift_state_t;
endpackage

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ninth_wr,
    input  logic              ninth_val,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] data_byte,
    input  logic              take,
    output logic              full,
    output logic [WORD_W-1:0] word,
    output logic              ovf
);
    hold_state_t st_d, st_q;
    logic        accept;

    always_comb begin
        st_d   = st_q;
        accept = data_wr && (!st_q.full || take);
        if (ninth_wr) st_d.ninth = ninth_val;
        if (take) st_d.full = 1'b0;
        if (accept) begin
            st_d.full = 1'b1;
            st_d.word = {st_q.ninth, data_byte};
        end else if (data_wr) begin
            st_d.ovf = 1'b1;
        end
        if (!en) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full = st_q.full;
    assign word = st_q.word;
    assign ovf  = st_q.ovf;

    // R8: the overflow record survives while enabled
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && en) |=> st_q.ovf);
    // R8: a full buffer keeps its character until handed over
    a_r8_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && !take && en) |=> (st_q.full && $stable(st_q.word)));
    // R9: a write coinciding with the hand-over is stored
    a_r9_accept_on_take: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && take && data_wr && en)
        |=> (st_q.full && st_q.word[BYTE_W-1:0] == $past(data_byte)));
    // R10: disabling empties the buffer and clears the record
    a_r10_buffer_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!st_q.full && !st_q.ovf));
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              nine_mode,
    input  logic              hold_full,
    input  logic [WORD_W-1:0] hold_word,
    output logic              take,
    output logic              line,
    output logic              idle
);
    shift_state_t         st_d, st_q;
    logic                 done;
    logic [FRAME_MAX-1:0] fresh;
    logic [CNT_W-1:0]     fresh_len;

    always_comb begin
        done      = st_q.busy && tick && (st_q.left == '0);
        take      = en && hold_full && (!st_q.busy || done);
        fresh     = {1'b1, (nine_mode ? hold_word[WORD_W-1] : 1'b1),
                     hold_word[BYTE_W-1:0], 1'b0};
        fresh_len = nine_mode ? CNT_W'(FRAME_MAX) : CNT_W'(FRAME_MAX - 1);
        st_d      = st_q;
        if (st_q.busy && tick) begin
            if (st_q.left == '0) begin
                if (take) begin
                    st_d.line = fresh[0];
                    st_d.sreg = {1'b1, fresh[FRAME_MAX-1:1]};
                    st_d.left = fresh_len - 1'b1;
                end else begin
                    st_d.busy = 1'b0;
                end
            end else begin
                st_d.line = st_q.sreg[0];
                st_d.sreg = {1'b1, st_q.sreg[FRAME_MAX-1:1]};
                st_d.left = st_q.left - 1'b1;
            end
        end else if (take) begin
            st_d.busy = 1'b1;
            st_d.sreg = fresh;
            st_d.left = fresh_len;
        end
        if (!en) begin
            st_d      = '0;
            st_d.line = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.line <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign line = st_q.line;
    assign idle = !st_q.busy;

    // R10: a disabled transmitter drives mark
    a_r10_line_high_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> st_q.line);
    // R4: the line only moves on a baud tick while enabled
    a_r4_line_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && (st_q.line != $past(st_q.line))) |-> $past(tick));
    // R6: the shifter empties only on a tick, after a stop bit
    a_r6_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !st_q.busy && $past(st_q.busy)) |-> ($past(tick) && st_q.line));
    // R3: an idle shifter picks up a waiting character at once
    a_r3_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !st_q.busy && hold_full) |=> st_q.busy);
endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              irq_en,
    input  logic              nine_mode,
    input  logic              ninth_wr,
    input  logic              ninth_val,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] data_byte,
    input  logic              baud_tick,
    output logic              ser_out,
    output logic              buf_empty,
    output logic              shift_empty,
    output logic              overflow,
    output logic              irq
);
    logic              hold_full;
    logic [WORD_W-1:0] hold_word;
    logic              take;

    sertx_holdbuf u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_en),
        .ninth_wr  (ninth_wr),
        .ninth_val (ninth_val),
        .data_wr   (data_wr),
        .data_byte (data_byte),
        .take      (take),
        .full      (hold_full),
        .word      (hold_word),
        .ovf       (overflow)
    );

    sertx_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_en),
        .tick      (baud_tick),
        .nine_mode (nine_mode),
        .hold_full (hold_full),
        .hold_word (hold_word),
        .take      (take),
        .line      (ser_out),
        .idle      (shift_empty)
    );

    assign buf_empty = tx_en && !hold_full;
    assign irq       = buf_empty && irq_en;

    // R2: an interrupt request is never raised while masked
    a_r2_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

// File: tb/dbuf_serial_tx_test.sv
module dbuf_serial_tx_test;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;

    logic       clk = 1'b0;
    logic       rst_n, tx_en, irq_en, nine_mode, ninth_wr, ninth_val, data_wr, baud_tick;
    logic [7:0] data_byte;
    logic       ser_out, buf_empty, shift_empty, overflow, irq;

    int checks = 0, errors = 0, cyc = 0;
    int tick_ph = 0, ticks_seen = 0, drain_cyc = 0;
    bit tick_run = 1'b0, mode9 = 1'b0;

    logic [8:0] rx_word [0:511];
    bit         rx_stop [0:511];
    int         rx_start[0:511];
    int         rx_n = 0;
    int         dst = 0, dcnt = 0, didx = 0, dstart = 0;
    logic [8:0] dacc;
    logic       prev_line = 1'b1;

    dbuf_serial_tx uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .irq_en(irq_en),
        .nine_mode(nine_mode), .ninth_wr(ninth_wr), .ninth_val(ninth_val),
        .data_wr(data_wr), .data_byte(data_byte), .baud_tick(baud_tick),
        .ser_out(ser_out), .buf_empty(buf_empty), .shift_empty(shift_empty),
        .overflow(overflow), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // line decoder: samples each bit on negedges, a tick period apart
    always @(negedge clk) begin
        if (!rst_n || !tx_en) begin
            dst = 0;
        end else if (dst == 0) begin
            if (prev_line && !ser_out) begin
                dst = 1; dcnt = TICK_DIV; didx = 1; dacc = '0; dstart = cyc;
            end
        end else begin
            dcnt = dcnt - 1;
            if (dcnt == 0) begin
                if (didx <= (mode9 ? 9 : 8)) dacc[didx-1] = ser_out;
                if (didx == (mode9 ? 10 : 9)) begin
                    rx_word[rx_n] = dacc; rx_stop[rx_n] = ser_out;
                    rx_start[rx_n] = dstart; rx_n = rx_n + 1; dst = 0;
                end else begin
                    didx = didx + 1; dcnt = TICK_DIV;
                end
            end
        end
        prev_line = ser_out;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (tick_run) begin
            tick_ph   = (tick_ph + 1) % TICK_DIV;
            baud_tick = (tick_ph == 0);
            if (baud_tick) ticks_seen++;
        end else begin
            baud_tick = 1'b0;
        end
    endtask

    task automatic put(input logic [7:0] b);
        data_byte = b; data_wr = 1'b1; step(); data_wr = 1'b0;
    endtask

    task automatic wait_drain();
        int g = 0;
        repeat (2) step();
        while (!shift_empty && g < 3000) begin step(); g++; end
        drain_cyc = cyc;
    endtask

    task automatic collide(input int offset, input bit accept);
        int base = rx_n;
        int t0;
        put(8'h11);
        t0 = ticks_seen;
        step();
        put(8'h22);
        while (ticks_seen != t0 + offset) step();
        put(8'h33);
        if (accept) begin
            chk("R9 overflow after write on hand-over tick", overflow, 0);
            chk("R9 buffer holds third character", buf_empty, 0);
        end else begin
            chk("R8 overflow after write into full buffer", overflow, 1);
        end
        wait_drain();
        chk(accept ? "R9 frames received" : "R8 frames received", rx_n - base, accept ? 3 : 2);
        chk("R8 first character", rx_word[base], 9'h011);
        chk("R8 second character", rx_word[base+1], 9'h022);
        if (accept) chk("R9 third character", rx_word[base+2], 9'h033);
        else        chk("R8 overflow stays set", overflow, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        checks++; errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        rst_n = 0; tx_en = 0; irq_en = 0; nine_mode = 0; ninth_wr = 0; ninth_val = 0;
        data_wr = 0; data_byte = '0; baud_tick = 0;
        repeat (3) step();
        chk("R1 line in reset", ser_out, 1);
        chk("R1 shifter empty in reset", shift_empty, 1);
        rst_n = 1; step();
        chk("R1 line idle", ser_out, 1);
        chk("R1 shifter empty", shift_empty, 1);
        chk("R1 buffer flag while disabled", buf_empty, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 irq", irq, 0);

        tx_en = 1; step();
        chk("R2 buffer empty on enable", buf_empty, 1);
        chk("R2 irq masked", irq, 0);
        irq_en = 1; step();
        chk("R2 irq raised", irq, 1);

        // R3 hand-over timing with ticks stopped
        put(8'hA5);
        chk("R3 buffer full after write", buf_empty, 0);
        chk("R3 shifter still empty", shift_empty, 1);
        chk("R3 irq low", irq, 0);
        step();
        chk("R3 buffer empty again", buf_empty, 1);
        chk("R3 shifter loaded", shift_empty, 0);
        chk("R4 line high before first tick", ser_out, 1);
        tick_run = 1;
        wait_drain();
        chk("R4 single frame data", rx_word[0][7:0], 8'hA5);
        chk("R4 single frame stop", rx_stop[0], 1);
        chk("R6 shifter empty at end of stop bit", drain_cyc - rx_start[0], 10 * TICK_DIV);
        chk("R4 line idle after frame", ser_out, 1);

        // R4/R7 exhaustive byte sweep, back to back
        base = rx_n;
        for (int i = 0; i < 256; i++) begin
            while (!buf_empty) step();
            put(i[7:0]);
        end
        wait_drain();
        chk("R7 frame count", rx_n - base, 256);
        for (int i = 0; i < 256; i++) begin
            chk("R4 byte value", rx_word[base+i][7:0], i);
            chk("R4 stop bit", rx_stop[base+i], 1);
            if (i > 0) chk("R7 no gap between frames", rx_start[base+i] - rx_start[base+i-1], 10 * TICK_DIV);
        end
        chk("R6 end of last 8-bit frame", drain_cyc - rx_start[base+255], 10 * TICK_DIV);

        // R5 nine-bit sweep
        nine_mode = 1; mode9 = 1;
        base = rx_n;
        for (int i = 0; i < 64; i++) begin
            while (!buf_empty) step();
            ninth_val = i[0] ^ i[2]; ninth_wr = 1; step(); ninth_wr = 0;
            put(8'(i * 37));
        end
        wait_drain();
        chk("R5 frame count", rx_n - base, 64);
        for (int i = 0; i < 64; i++) begin
            chk("R5 nine-bit value", rx_word[base+i], {i[0] ^ i[2], 8'(i * 37)});
            chk("R5 stop bit", rx_stop[base+i], 1);
            if (i > 0) chk("R7 no gap 9-bit", rx_start[base+i] - rx_start[base+i-1], 11 * TICK_DIV);
        end
        chk("R6 end of last 9-bit frame", drain_cyc - rx_start[base+63], 11 * TICK_DIV);
        base = rx_n;
        ninth_val = 1; ninth_wr = 1; step(); ninth_wr = 0;
        put(8'h3C);
        ninth_val = 0; ninth_wr = 1; step(); ninth_wr = 0;
        wait_drain();
        chk("R5 ninth bit latched at data write", rx_word[base], 9'h13C);
        nine_mode = 0; mode9 = 0;

        // R8 write one tick early is dropped; R9 write on hand-over accepted
        collide(10, 1'b0);
        tx_en = 0; step(); tx_en = 1; step();
        chk("R10 overflow cleared by disable", overflow, 0);
        collide(11, 1'b1);
        chk("R9 no overflow", overflow, 0);

        // R10 abort mid-frame
        base = rx_n;
        put(8'hF0);
        repeat (14) step();
        put(8'h0F);
        tx_en = 0; step();
        chk("R10 line high after abort", ser_out, 1);
        chk("R10 shifter empty after abort", shift_empty, 1);
        chk("R10 buffer flag disabled", buf_empty, 0);
        chk("R10 irq low", irq, 0);
        put(8'h55);
        tx_en = 1; step();
        chk("R10 write while disabled discarded", buf_empty, 1);
        chk("R10 shifter stays empty", shift_empty, 1);
        repeat (60) step();
        chk("R10 no frame after abort", rx_n - base, 0);
        chk("R10 line idle", ser_out, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule